// File: doc/BRIEF.md
# Shared Reversing Shifter

This block is the shift datapath of a 32-bit integer execution unit. It performs logical, arithmetic and ones-filling shifts, rotates, bit reversal, byte swap, byte-wise OR-combine and the four single-bit operations (set, clear, invert, extract). All of them use a single right-shift network. A left shift bit-reverses its operand in front of the network and bit-reverses the network's output behind it. For the single-bit mask operations, a select in front of the network swaps the operand for the constant 1.

Each cycle the block takes an operation code, the operand `src_i` and a shift amount `amt_i` (a register value or an immediate, chosen upstream). It computes the result combinationally and registers it. The result is visible at `res_o` after the next rising clock edge.

Top module: `rsh_unit`

## Requirements
- R1: With `rst` high at a rising edge, `res_o` becomes 0. Otherwise `res_o` takes, at each rising edge, the result of the `op_i`, `src_i` and `amt_i` present before that edge.
- R2: Op 0 shifts left logical and op 1 shifts right logical, both filling with 0. Only `amt_i[4:0]` is used for every shift and single-bit op, so the upper amount bits have no effect.
- R3: Op 2 shifts right arithmetic and fills the vacated bits with `src_i[31]`.
- R4: Op 3 shifts left and op 4 shifts right, both filling the vacated bits with 1.
- R5: Op 5 rotates left and op 6 rotates right by `amt_i[4:0]`. A zero amount returns `src_i` unchanged.
- R6: Op 7 returns `src_i` bit-reversed, so result bit i is `src_i[31-i]`. The amount is ignored.
- R7: Op 8 returns `src_i` with its four bytes in reverse order. The amount is ignored.
- R8: Op 9 returns, for each byte, 0xFF if the matching byte of `src_i` is non-zero and 0x00 if it is zero. The amount is ignored.
- R9: Ops 10, 11 and 12 return `src_i` with bit `amt_i[4:0]` set, cleared or inverted respectively. All other bits are unchanged.
- R10: Op 13 returns bit `amt_i[4:0]` of `src_i` in bit 0, with bits 31:1 zero.
- R11: Op codes 14 and 15 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code (see requirements) |
| src_i | input | 32 | Operand |
| amt_i | input | 32 | Shift amount or bit index; only bits 4:0 used |
| res_o | output | 32 | Registered result |

## Verification
Each operation is driven with several amounts, including 0, 1, 31 and an amount with upper bits set. Amount 0 shows whether the reversal on the left path is undone correctly. Amount 31 checks the far end of the fill and of the rotate wrap. The amount with upper bits set would expose a wider amount reaching the network. Operands with bit 31 set and clear separate the arithmetic fill from the logical and ones fills. Operands with alternating, single-bit and mixed-zero bytes separate bit reversal from byte swap and show the per-byte OR-combine decisions. The single-bit ops are tried at bit 0 and bit 31 on operands where the target bit starts as 0 and as 1.

// File: rtl/rsh_pkg.sv
package rsh_pkg;
  typedef enum logic [3:0] {
    OP_SLL  = 4'd0,
    OP_SRL  = 4'd1,
    OP_SRA  = 4'd2,
    OP_SLO  = 4'd3,
    OP_SRO  = 4'd4,
    OP_ROL  = 4'd5,
    OP_ROR  = 4'd6,
    OP_REV  = 4'd7,
    OP_REV8 = 4'd8,
    OP_ORCB = 4'd9,
    OP_BSET = 4'd10,
    OP_BCLR = 4'd11,
    OP_BINV = 4'd12,
    OP_BEXT = 4'd13
  } rsh_op_e;

  function automatic logic is_left(input logic [3:0] op);
    return op == OP_SLL || op == OP_SLO || op == OP_ROL ||
           op == OP_BSET || op == OP_BCLR || op == OP_BINV;
  endfunction

  function automatic logic is_mask(input logic [3:0] op);
    return op == OP_BSET || op == OP_BCLR || op == OP_BINV;
  endfunction
endpackage

// File: rtl/rsh_front.sv
module rsh_front
  import rsh_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int SHW = $clog2(XLEN)
) (
  input  logic [3:0]      op,
  input  logic [XLEN-1:0] src,
  input  logic [XLEN-1:0] amt,
  output logic [XLEN-1:0] net_lo,
  output logic [XLEN-2:0] net_hi,
  output logic [SHW-1:0]  net_amt
);
  logic [XLEN-1:0] base;
  logic [XLEN-1:0] base_rev;
  logic            rev_in;
  logic            fill;
  logic            rotate;
  logic            no_shift;

  for (genvar i = 0; i < XLEN; i++) begin : g_rev
    assign base_rev[i] = base[XLEN-1-i];
  end

  always_comb begin
    base     = is_mask(op) ? XLEN'(1) : src;
    rev_in   = is_left(op) || op == OP_REV || op == OP_REV8;
    rotate   = op == OP_ROL || op == OP_ROR;
    no_shift = op == OP_REV || op == OP_REV8 || op == OP_ORCB;
    unique case (op)
      OP_SRA:        fill = src[XLEN-1];
      OP_SLO, OP_SRO: fill = 1'b1;
      default:       fill = 1'b0;
    endcase
    net_lo  = rev_in ? base_rev : base;
    net_hi  = rotate ? net_lo[XLEN-2:0] : {(XLEN-1){fill}};
    net_amt = no_shift ? '0 : amt[SHW-1:0];
  end
endmodule

// File: rtl/rsh_rnet.sv
module rsh_rnet #(
  parameter int XLEN = 32,
  localparam int SHW = $clog2(XLEN),
  localparam int NW  = 2*XLEN-1
) (
  input  logic [XLEN-1:0] lo,
  input  logic [XLEN-2:0] hi,
  input  logic [SHW-1:0]  amt,
  output logic [XLEN-1:0] out
);
  logic [NW-1:0] stage [SHW+1];

  assign stage[0] = {hi, lo};

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int D = 1 << k;
    assign stage[k+1] = amt[k] ? {{D{1'b0}}, stage[k][NW-1:D]} : stage[k];
  end

  assign out = stage[SHW][XLEN-1:0];
endmodule

// File: rtl/rsh_back.sv
module rsh_back
  import rsh_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int NB = XLEN / 8
) (
  input  logic [3:0]      op,
  input  logic [XLEN-1:0] src,
  input  logic [XLEN-1:0] net,
  output logic [XLEN-1:0] res
);
  logic [XLEN-1:0] net_rev;
  logic [XLEN-1:0] byte_rev;
  logic [XLEN-1:0] orc;

  for (genvar i = 0; i < XLEN; i++) begin : g_rev
    assign net_rev[i] = net[XLEN-1-i];
  end

  for (genvar b = 0; b < NB; b++) begin : g_byte
    for (genvar j = 0; j < 8; j++) begin : g_bit
      assign byte_rev[8*b+j] = net[8*b+7-j];
    end
    assign orc[8*b +: 8] = {8{|net[8*b +: 8]}};
  end

  always_comb begin
    unique case (op)
      OP_SLL, OP_SLO, OP_ROL:         res = net_rev;
      OP_SRL, OP_SRA, OP_SRO, OP_ROR: res = net;
      OP_REV:  res = net;
      OP_REV8: res = byte_rev;
      OP_ORCB: res = orc;
      OP_BSET: res = src | net_rev;
      OP_BCLR: res = src & ~net_rev;
      OP_BINV: res = src ^ net_rev;
      OP_BEXT: res = {{(XLEN-1){1'b0}}, net[0]};
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/rsh_unit.sv
module rsh_unit #(
  parameter int XLEN = 32,
  localparam int SHW = $clog2(XLEN)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [3:0]      op_i,
  input  logic [XLEN-1:0] src_i,
  input  logic [XLEN-1:0] amt_i,
  output logic [XLEN-1:0] res_o
);
  logic [XLEN-1:0] net_lo;
  logic [XLEN-2:0] net_hi;
  logic [SHW-1:0]  net_amt;
  logic [XLEN-1:0] net_out;
  logic [XLEN-1:0] res_d;

  rsh_front #(.XLEN(XLEN)) u_front (
    .op(op_i), .src(src_i), .amt(amt_i),
    .net_lo(net_lo), .net_hi(net_hi), .net_amt(net_amt)
  );

  rsh_rnet #(.XLEN(XLEN)) u_rnet (
    .lo(net_lo), .hi(net_hi), .amt(net_amt), .out(net_out)
  );

  rsh_back #(.XLEN(XLEN)) u_back (
    .op(op_i), .src(src_i), .net(net_out), .res(res_d)
  );

  always_ff @(posedge clk) begin
    if (rst) res_o <= '0;
    else     res_o <= res_d;
  end
endmodule

// File: rtl/rsh_unit_chk.sv
module rsh_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic [3:0]      op_i,
  input logic [XLEN-1:0] src_i,
  input logic [XLEN-1:0] amt_i,
  input logic [XLEN-1:0] res_o
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> res_o == '0); // R1

  AST_SRA_SIGN_KEPT: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(op_i) == 4'd2) |-> res_o[XLEN-1] == $past(src_i[XLEN-1])); // R3

  AST_ROT_POPCOUNT: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && ($past(op_i) == 4'd5 || $past(op_i) == 4'd6))
      |-> $countones(res_o) == $countones($past(src_i))); // R5

  AST_REV_POPCOUNT: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && ($past(op_i) == 4'd7 || $past(op_i) == 4'd8))
      |-> $countones(res_o) == $countones($past(src_i))); // R6

  AST_ORCB_MULT8: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(op_i) == 4'd9) |-> ($countones(res_o) % 8) == 0); // R8

  AST_BINV_ONE_FLIP: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(op_i) == 4'd12) |-> $countones(res_o ^ $past(src_i)) == 1); // R9

  AST_BSET_BCLR_AT_MOST_ONE: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && ($past(op_i) == 4'd10 || $past(op_i) == 4'd11))
      |-> $countones(res_o ^ $past(src_i)) <= 1); // R9

  AST_BEXT_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(op_i) == 4'd13) |-> res_o[XLEN-1:1] == '0); // R10

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(op_i) >= 4'd14) |-> res_o == '0); // R11
endmodule

bind rsh_unit rsh_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst(rst), .op_i(op_i), .src_i(src_i), .amt_i(amt_i), .res_o(res_o)
);

// File: tb/rsh_unit_tb.sv
module rsh_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op_i = '0;
  logic [31:0] src_i = '0;
  logic [31:0] amt_i = '0;
  logic [31:0] res_o;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  rsh_unit u_dut (.clk(clk), .rst(rst), .op_i(op_i), .src_i(src_i),
                  .amt_i(amt_i), .res_o(res_o));

  function automatic logic [31:0] model(input logic [3:0] op,
                                        input logic [31:0] a,
                                        input logic [31:0] amt);
    int s;
    logic [31:0] r;
    s = int'(amt[4:0]);
    r = '0;
    case (op)
      4'd0:  r = a << s;
      4'd1:  r = a >> s;
      4'd2:  r = 32'($signed(a) >>> s);
      4'd3:  r = ~((~a) << s);
      4'd4:  r = ~((~a) >> s);
      4'd5:  r = (s == 0) ? a : ((a << s) | (a >> (32 - s)));
      4'd6:  r = (s == 0) ? a : ((a >> s) | (a << (32 - s)));
      4'd7:  for (int i = 0; i < 32; i++) r[i] = a[31-i];
      4'd8:  r = {a[7:0], a[15:8], a[23:16], a[31:24]};
      4'd9:  for (int b = 0; b < 4; b++) r[8*b +: 8] = (a[8*b +: 8] != 0) ? 8'hFF : 8'h00;
      4'd10: r = a | (32'd1 << s);
      4'd11: r = a & ~(32'd1 << s);
      4'd12: r = a ^ (32'd1 << s);
      4'd13: r = {31'd0, a[s]};
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check(input string tag, input logic [3:0] op,
                       input logic [31:0] a, input logic [31:0] amt);
    logic [31:0] exp;
    exp = model(op, a, amt);
    @(negedge clk);
    op_i = op; src_i = a; amt_i = amt;
    @(negedge clk);
    checks++;
    if (res_o !== exp) begin
      errors++;
      $display("FAIL %s op=%0d src=%h amt=%h actual=%h expected=%h",
               tag, op, a, amt, res_o, exp);
    end
  endtask

  task automatic t_reset();
    // R1: reset clears, then result follows inputs after one edge
    @(negedge clk);
    op_i = 4'd12; src_i = 32'hFFFF_FFFF; amt_i = 32'd3; rst = 1'b1;
    @(negedge clk);
    checks++;
    if (res_o !== 32'd0) begin
      errors++;
      $display("FAIL R1 reset actual=%h expected=%h", res_o, 32'd0);
    end
    rst = 1'b0;
    check("R1", 4'd0, 32'h0000_0001, 32'd4);
  endtask

  task automatic t_logical();
    // R2
    check("R2", 4'd0, 32'h8000_0001, 32'd0);
    check("R2", 4'd0, 32'hDEAD_BEEF, 32'd31);
    check("R2", 4'd1, 32'h8000_0001, 32'd1);
    check("R2", 4'd1, 32'hDEAD_BEEF, 32'hFFFF_FFE7);
    check("R2", 4'd0, 32'h1234_5678, 32'h0000_0128);
  endtask

  task automatic t_arith();
    // R3
    check("R3", 4'd2, 32'h8000_0000, 32'd31);
    check("R3", 4'd2, 32'h8765_4321, 32'd4);
    check("R3", 4'd2, 32'h7654_3210, 32'd4);
    check("R3", 4'd2, 32'hF000_000F, 32'd0);
  endtask

  task automatic t_ones();
    // R4
    check("R4", 4'd3, 32'h0000_0000, 32'd5);
    check("R4", 4'd3, 32'h1234_5678, 32'd31);
    check("R4", 4'd4, 32'h0000_0000, 32'd8);
    check("R4", 4'd4, 32'h8000_0000, 32'd1);
  endtask

  task automatic t_rotate();
    // R5
    check("R5", 4'd5, 32'h8000_0001, 32'd1);
    check("R5", 4'd5, 32'h1234_5678, 32'd0);
    check("R5", 4'd6, 32'h1234_5678, 32'd31);
    check("R5", 4'd6, 32'h0000_00F1, 32'd4);
    check("R5", 4'd5, 32'hCAFE_F00D, 32'hFFFF_FFF0);
  endtask

  task automatic t_reverse();
    // R6, R7
    check("R6", 4'd7, 32'h0000_0001, 32'd9);
    check("R6", 4'd7, 32'h1234_5678, 32'd0);
    check("R7", 4'd8, 32'h1234_5678, 32'd7);
    check("R7", 4'd8, 32'h80C0_0103, 32'd0);
  endtask

  task automatic t_orcb();
    // R8
    check("R8", 4'd9, 32'h0001_8000, 32'd3);
    check("R8", 4'd9, 32'h0000_0000, 32'd0);
    check("R8", 4'd9, 32'h1000_0020, 32'd0);
  endtask

  task automatic t_single();
    // R9, R10
    check("R9", 4'd10, 32'h0000_0000, 32'd31);
    check("R9", 4'd10, 32'h0000_0001, 32'd0);
    check("R9", 4'd11, 32'hFFFF_FFFF, 32'd0);
    check("R9", 4'd11, 32'h0F0F_0F0F, 32'd4);
    check("R9", 4'd12, 32'hAAAA_AAAA, 32'd31);
    check("R9", 4'd12, 32'h5555_5555, 32'h0000_0020);
    check("R10", 4'd13, 32'h8000_0000, 32'd31);
    check("R10", 4'd13, 32'hFFFF_FFFE, 32'd0);
    check("R10", 4'd13, 32'h0000_0010, 32'h0000_0024);
  endtask

  task automatic t_unused();
    // R11
    check("R11", 4'd14, 32'hFFFF_FFFF, 32'd3);
    check("R11", 4'd15, 32'h1234_5678, 32'd0);
  endtask

  initial begin
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL watchdog actual=%0d cycles expected=completion", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_logical();
    t_arith();
    t_ones();
    t_rotate();
    t_reverse();
    t_orcb();
    t_single();
    t_unused();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule